// File: doc/BRIEF.md
# Multi-function I/O chip configuration port

This block is the byte-wide configuration front end of a multi-function I/O chip. Software reaches it through two adjacent one-byte I/O locations: an index port that names a configuration register and a data port that reads or writes the named register. Access is locked after reset. The software opens it by writing a four-byte key to the index port, and closes it again by writing a control register.

While access is open, a global device-select register picks one of the chip's logical devices. The banked registers then reach that device's own copies of an activate flag, two 16-bit base addresses and an interrupt number. The stored values leave the block as steady per-device outputs, which the chip's functional units and address decoders use. Seven logical devices are built in: numbers 0, 1, 4, 5, 6, 7 and 10.

The bus is a simple strobe interface. `bus_wr` or `bus_rd` is held high for one clock with a valid address. A write takes effect at that clock edge. Read data is combinational and valid while `bus_rd` is high.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset, configuration access is closed, the select register and index register hold 0, and every device output (enable, both base addresses, IRQ) is 0.
- R2: Writing the bytes 0x87, 0x01, 0x55, 0x55 in that order to the index port (0x2E) opens configuration access at the edge of the last write.
- R3: A byte that breaks the key sequence restarts matching; if that byte is 0x87 it counts as the first key byte of a new attempt.
- R4: While access is closed, data-port (0x2F) writes change nothing, data-port reads return 0xFF, and index-port reads return 0xFF.
- R5: While access is open, an index-port write loads the index register, and an index-port read returns it.
- R6: A data write of 0x02 to register 0x02 closes access; any other value written there leaves access open, and reading register 0x02 returns 0x00.
- R7: Register 0x07 is the global device-select register; it is written and read back in full and is shared by all banks; other registers below 0x30 read 0x00.
- R8: Register 0x30 is the banked activate flag: bit 0 of the written byte drives that device's bit of `dev_en`, and a read returns 0x00 or 0x01. Output bit i belongs to the i-th device in the ascending number list 0, 1, 4, 5, 6, 7, 10.
- R9: Registers 0x60 (high byte) and 0x61 (low byte) form base address 0, and 0x62/0x63 form base address 1. Both are driven on `dev_base0`/`dev_base1` and read back byte-wise.
- R10: Register 0x70 holds the interrupt number in its low four bits, drives `dev_irq` and reads back zero-extended; other banked offsets read 0x00.
- R11: When the select register holds a number with no device, every banked register reads 0xFF and banked writes change no output.
- R12: A configuration write changes only the selected device's outputs, and the change is visible from the next clock edge.
- R13: Reads and writes at addresses other than the two ports are ignored and return 0x00 on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_addr | input | 16 | I/O address of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, valid during `bus_rd` |
| dev_en | output | 7 | Per-device activate flag |
| dev_base0 | output | 7x16 | Per-device base address 0 |
| dev_base1 | output | 7x16 | Per-device base address 1 |
| dev_irq | output | 7x4 | Per-device interrupt number |

## Verification
Every cycle, the assertions check these rules. Access opens only on the final key byte. Outputs stay frozen and data reads return 0xFF while access is closed. The exit write always closes access. The enable outputs move only after an activate-register write. The bench's scenarios are needed for the rest, because each of these depends on a history of bytes: restart of the key matcher on a stray 0x87, the bank routing for each device number, the 0xFF response and write blocking for unimplemented numbers, and isolation between banks. A reference model checks those scenarios across random mixes of unlocks, index moves, writes and reads.

// File: rtl/sio_cfg_pkg.sv
// Package: shared constants of the configuration port.
// Assumes byte-wide registers and an 8-bit register index.
package sio_cfg_pkg;
    localparam int          KEY_LEN   = 4;
    // Unlock key, element 0 is written first.
    localparam logic [KEY_LEN-1:0][7:0] KEY_BYTES = {8'h55, 8'h55, 8'h01, 8'h87};

    localparam logic [7:0] REG_CTRL   = 8'h02;
    localparam logic [7:0] REG_SEL    = 8'h07;
    localparam logic [7:0] BANK_FIRST = 8'h30;
    localparam logic [7:0] REG_ACT    = 8'h30;
    localparam logic [7:0] REG_B0_HI  = 8'h60;
    localparam logic [7:0] REG_B0_LO  = 8'h61;
    localparam logic [7:0] REG_B1_HI  = 8'h62;
    localparam logic [7:0] REG_B1_LO  = 8'h63;
    localparam logic [7:0] REG_IRQ    = 8'h70;
    localparam logic [7:0] CTRL_CLOSE = 8'h02;
    localparam logic [7:0] NO_DEV     = 8'hFF;
endpackage

// File: rtl/sio_key_unlock.sv
// Module: key matcher and access-mode flag.
// Follows index-port bytes while access is closed and opens access after
// the full key. A mismatching byte restarts matching, and a mismatch equal
// to the first key byte counts as a new first byte. Closes on exit_req.
module sio_key_unlock
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] idx_byte,
    input  logic       exit_req,
    output logic       cfg_mode
);
    localparam int STEP_W = $clog2(KEY_LEN);

    logic [STEP_W-1:0] step_q;
    logic              open_q;

    // Purpose: advance, restart or complete the key match; track open state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            open_q <= 1'b0;
        end else if (open_q) begin
            if (exit_req) begin
                open_q <= 1'b0;
                step_q <= '0;
            end
        end else if (idx_wr) begin
            if (idx_byte == KEY_BYTES[step_q]) begin
                if (step_q == STEP_W'(KEY_LEN - 1)) begin
                    open_q <= 1'b1;
                    step_q <= '0;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end else if (idx_byte == KEY_BYTES[0]) begin
                step_q <= STEP_W'(1);
            end else begin
                step_q <= '0;
            end
        end
    end

    assign cfg_mode = open_q;
endmodule

// File: rtl/sio_dev_bank.sv
// Module: register bank of one logical device.
// Holds the activate flag, two 16-bit base addresses and an IRQ number.
// Assumes wr_en is already qualified with open access and bank select.
module sio_dev_bank
    import sio_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  reg_off,
    input  logic [7:0]  wdata,
    output logic        act,
    output logic [15:0] base0,
    output logic [15:0] base1,
    output logic [3:0]  irq,
    output logic [7:0]  rd_byte
);
    // Purpose: store banked register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act   <= 1'b0;
            base0 <= '0;
            base1 <= '0;
            irq   <= '0;
        end else if (wr_en) begin
            case (reg_off)
                REG_ACT:   act         <= wdata[0];
                REG_B0_HI: base0[15:8] <= wdata;
                REG_B0_LO: base0[7:0]  <= wdata;
                REG_B1_HI: base1[15:8] <= wdata;
                REG_B1_LO: base1[7:0]  <= wdata;
                REG_IRQ:   irq         <= wdata[3:0];
                default:   ;
            endcase
        end
    end

    // Purpose: present the addressed banked register for a read.
    always_comb begin
        case (reg_off)
            REG_ACT:   rd_byte = {7'd0, act};
            REG_B0_HI: rd_byte = base0[15:8];
            REG_B0_LO: rd_byte = base0[7:0];
            REG_B1_HI: rd_byte = base1[15:8];
            REG_B1_LO: rd_byte = base1[7:0];
            REG_IRQ:   rd_byte = {4'd0, irq};
            default:   rd_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/sio_cfg_port.sv
// Module: index/data configuration port of a multi-function I/O chip.
// Decodes the two port addresses and keeps the index and device-select
// registers. Routes banked accesses to the bank whose device number
// matches and builds the read byte. Assumes one-cycle bus strobes.
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h002E,
    parameter int                NDEV     = 7,
    parameter logic [NDEV-1:0][7:0] DEV_NUM = {8'd10, 8'd7, 8'd6, 8'd5, 8'd4, 8'd1, 8'd0}
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [7:0]             bus_wdata,
    output logic [7:0]             bus_rdata,
    output logic [NDEV-1:0]        dev_en,
    output logic [NDEV-1:0][15:0]  dev_base0,
    output logic [NDEV-1:0][15:0]  dev_base1,
    output logic [NDEV-1:0][3:0]   dev_irq
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(IDX_ADDR + 1'b1);

    logic            cfg_mode;
    logic [7:0]      idx_q;
    logic [7:0]      sel_q;
    logic            at_idx, at_data;
    logic            idx_wr, cfg_wr, exit_req, banked;
    logic [NDEV-1:0] hit;
    logic [7:0]      bank_rd [NDEV];
    logic [7:0]      bank_byte;
    logic [7:0]      data_byte;

    assign at_idx   = (bus_addr == IDX_ADDR);
    assign at_data  = (bus_addr == DATA_ADDR);
    assign idx_wr   = bus_wr && at_idx;
    assign cfg_wr   = bus_wr && at_data && cfg_mode;
    assign exit_req = cfg_wr && (idx_q == REG_CTRL) && (bus_wdata == CTRL_CLOSE);
    assign banked   = (idx_q >= BANK_FIRST);

    sio_key_unlock u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr && !cfg_mode),
        .idx_byte (bus_wdata),
        .exit_req (exit_req),
        .cfg_mode (cfg_mode)
    );

    // Purpose: hold the register index and the global device select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            sel_q <= '0;
        end else begin
            if (idx_wr && cfg_mode)
                idx_q <= bus_wdata;
            if (cfg_wr && idx_q == REG_SEL)
                sel_q <= bus_wdata;
        end
    end

    for (genvar i = 0; i < NDEV; i++) begin : g_dev
        assign hit[i] = (sel_q == DEV_NUM[i]);
        sio_dev_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_wr && banked && hit[i]),
            .reg_off (idx_q),
            .wdata   (bus_wdata),
            .act     (dev_en[i]),
            .base0   (dev_base0[i]),
            .base1   (dev_base1[i]),
            .irq     (dev_irq[i]),
            .rd_byte (bank_rd[i])
        );
    end

    // Purpose: merge the read byte of the selected bank.
    always_comb begin
        bank_byte = 8'h00;
        for (int i = 0; i < NDEV; i++)
            if (hit[i])
                bank_byte = bank_byte | bank_rd[i];
    end

    // Purpose: form the data-port read value from mode, index and select.
    always_comb begin
        if (!cfg_mode)
            data_byte = NO_DEV;
        else if (!banked)
            data_byte = (idx_q == REG_SEL) ? sel_q : 8'h00;
        else if (|hit)
            data_byte = bank_byte;
        else
            data_byte = NO_DEV;
    end

    // Purpose: drive the bus read data for the addressed port.
    always_comb begin
        if (bus_rd && at_idx)
            bus_rdata = cfg_mode ? idx_q : NO_DEV;
        else if (bus_rd && at_data)
            bus_rdata = data_byte;
        else
            bus_rdata = 8'h00;
    end
endmodule

// File: rtl/sio_cfg_port_chk.sv
// Module: protocol checker bound to sio_cfg_port.
// Watches the bus, the access flag, the index register and the enables.
module sio_cfg_port_chk #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h002E,
    parameter int                NDEV     = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              cfg_mode,
    input logic [7:0]        idx_q,
    input logic [NDEV-1:0]   dev_en
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(IDX_ADDR + 1'b1);

    logic past_ok;

    // Purpose: mark cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_open_on_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(cfg_mode)) |->
        $past(bus_wr && bus_addr == IDX_ADDR && bus_wdata == 8'h55));

    assert_frozen_when_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(cfg_mode)) |-> $stable(dev_en));

    assert_closed_read_ff_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && bus_rd && bus_addr == DATA_ADDR) |-> (bus_rdata == 8'hFF));

    assert_exit_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cfg_mode && bus_wr && bus_addr == DATA_ADDR &&
                          idx_q == 8'h02 && bus_wdata == 8'h02)) |-> !cfg_mode);

    assert_en_after_act_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$stable(dev_en)) |->
        $past(bus_wr && bus_addr == DATA_ADDR && idx_q == 8'h30));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
    .ADDR_W   (ADDR_W),
    .IDX_ADDR (IDX_ADDR),
    .NDEV     (NDEV)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_mode  (cfg_mode),
    .idx_q     (idx_q),
    .dev_en    (dev_en)
);

// File: tb/sio_cfg_port_bench.sv
`timescale 1ns/1ps
module sio_cfg_port_bench;
    localparam int NDEV = 7;
    localparam logic [15:0] IDX = 16'h002E;
    localparam logic [15:0] DAT = 16'h002F;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  bus_wr = 1'b0;
    logic                  bus_rd = 1'b0;
    logic [15:0]           bus_addr = '0;
    logic [7:0]            bus_wdata = '0;
    logic [7:0]            bus_rdata;
    logic [NDEV-1:0]       dev_en;
    logic [NDEV-1:0][15:0] dev_base0;
    logic [NDEV-1:0][15:0] dev_base1;
    logic [NDEV-1:0][3:0]  dev_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    bit         m_open;
    int         m_step;
    logic [7:0] m_idx, m_sel;
    bit         m_en  [NDEV];
    logic [15:0] m_b0 [NDEV];
    logic [15:0] m_b1 [NDEV];
    logic [3:0]  m_irq [NDEV];

    sio_cfg_port u_sio_cfg_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_en(dev_en), .dev_base0(dev_base0), .dev_base1(dev_base1),
        .dev_irq(dev_irq)
    );

    always #2.5 clk = ~clk;

    function automatic int slot_of(logic [7:0] num);
        case (num)
            8'd0: return 0;  8'd1: return 1;  8'd4: return 2;  8'd5: return 3;
            8'd6: return 4;  8'd7: return 5;  8'd10: return 6;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] key_at(int s);
        case (s)
            0: return 8'h87;
            1: return 8'h01;
            default: return 8'h55;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(logic [15:0] a);
        int s;
        if (a == IDX) return m_open ? m_idx : 8'hFF;
        if (a != DAT) return 8'h00;
        if (!m_open) return 8'hFF;
        if (m_idx < 8'h30) return (m_idx == 8'h07) ? m_sel : 8'h00;
        s = slot_of(m_sel);
        if (s < 0) return 8'hFF;
        case (m_idx)
            8'h30: return {7'd0, m_en[s]};
            8'h60: return m_b0[s][15:8];
            8'h61: return m_b0[s][7:0];
            8'h62: return m_b1[s][15:8];
            8'h63: return m_b1[s][7:0];
            8'h70: return {4'd0, m_irq[s]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_open = 0; m_step = 0; m_idx = 0; m_sel = 0;
        for (int i = 0; i < NDEV; i++) begin
            m_en[i] = 0; m_b0[i] = 0; m_b1[i] = 0; m_irq[i] = 0;
        end
    endtask

    task automatic model_write(logic [15:0] a, logic [7:0] d);
        int s;
        if (a == IDX) begin
            if (m_open) m_idx = d;
            else if (d == key_at(m_step)) begin
                if (m_step == 3) begin m_open = 1; m_step = 0; end
                else m_step++;
            end else m_step = (d == 8'h87) ? 1 : 0;
        end else if (a == DAT && m_open) begin
            if (m_idx == 8'h02 && d == 8'h02) begin m_open = 0; m_step = 0; end
            else if (m_idx == 8'h07) m_sel = d;
            else if (m_idx >= 8'h30) begin
                s = slot_of(m_sel);
                if (s >= 0) case (m_idx)
                    8'h30: m_en[s] = d[0];
                    8'h60: m_b0[s][15:8] = d;
                    8'h61: m_b0[s][7:0] = d;
                    8'h62: m_b1[s][15:8] = d;
                    8'h63: m_b1[s][7:0] = d;
                    8'h70: m_irq[s] = d[3:0];
                    default: ;
                endcase
            end
        end
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_outputs(string req);
        for (int i = 0; i < NDEV; i++) begin
            check(req, 32'(dev_en[i]), 32'(m_en[i]));
            check(req, 32'(dev_base0[i]), 32'(m_b0[i]));
            check(req, 32'(dev_base1[i]), 32'(m_b1[i]));
            check(req, 32'(dev_irq[i]), 32'(m_irq[i]));
        end
    endtask

    // Write: drive at a falling edge, the write lands at the rising edge,
    // outputs are compared at the next falling edge.
    task automatic io_wr(logic [15:0] a, logic [7:0] d, string req);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
        check_outputs(req);
    endtask

    task automatic io_rd(logic [15:0] a, string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(req, 32'(bus_rdata), 32'(exp_read(a)));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic unlock(string req);
        io_wr(IDX, 8'h87, req); io_wr(IDX, 8'h01, req);
        io_wr(IDX, 8'h55, req); io_wr(IDX, 8'h55, req);
    endtask

    function automatic logic [7:0] pick_reg(int n);
        case (n % 10)
            0: return 8'h02; 1: return 8'h07; 2: return 8'h30; 3: return 8'h60;
            4: return 8'h61; 5: return 8'h62; 6: return 8'h63; 7: return 8'h70;
            8: return 8'h30;
            default: return 8'($urandom % 256);
        endcase
    endfunction

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int r;
        logic [7:0] d;
        void'($urandom(32'd20240607));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_outputs("R1");
        io_rd(IDX, "R1"); io_rd(DAT, "R4");
        // R4: closed port ignores writes
        io_wr(DAT, 8'h01, "R4");
        io_rd(DAT, "R4");
        // R3: broken key, then stray 0x87 restarts
        io_wr(IDX, 8'h87, "R3"); io_wr(IDX, 8'h01, "R3");
        io_wr(IDX, 8'h55, "R3"); io_wr(IDX, 8'h00, "R3");
        io_rd(IDX, "R3");
        io_wr(IDX, 8'h87, "R3"); io_wr(IDX, 8'h01, "R3");
        io_wr(IDX, 8'h87, "R3"); io_wr(IDX, 8'h01, "R3");
        io_wr(IDX, 8'h55, "R3"); io_wr(IDX, 8'h55, "R3");
        io_rd(IDX, "R3");
        check("R3 open", 32'(m_open), 32'd1);
        // R5/R7: index and select
        io_wr(IDX, 8'h07, "R5"); io_rd(IDX, "R5");
        io_wr(DAT, 8'h04, "R7"); io_rd(DAT, "R7");
        io_wr(IDX, 8'h05, "R7"); io_rd(DAT, "R7");
        // R8/R9/R10/R12 on device 4 (slot 2)
        io_wr(IDX, 8'h30, "R8"); io_wr(DAT, 8'hF1, "R8"); io_rd(DAT, "R8");
        check("R8 slot", 32'(dev_en), 32'h04);
        io_wr(IDX, 8'h60, "R9"); io_wr(DAT, 8'h02, "R9");
        io_wr(IDX, 8'h61, "R9"); io_wr(DAT, 8'h90, "R9");
        check("R9", 32'(dev_base0[2]), 32'h0290);
        io_wr(IDX, 8'h63, "R9"); io_wr(DAT, 8'hA5, "R9"); io_rd(DAT, "R9");
        io_wr(IDX, 8'h70, "R10"); io_wr(DAT, 8'hFB, "R10"); io_rd(DAT, "R10");
        io_wr(IDX, 8'h71, "R10"); io_rd(DAT, "R10");
        // R11: unimplemented number 2
        io_wr(IDX, 8'h07, "R11"); io_wr(DAT, 8'h02, "R11");
        io_wr(IDX, 8'h30, "R11"); io_rd(DAT, "R11");
        io_wr(DAT, 8'h01, "R11");
        check("R11", 32'(dev_en), 32'h04);
        // R13: foreign address
        io_wr(16'h002C, 8'h07, "R13"); io_rd(16'h002C, "R13"); io_rd(IDX, "R13");
        // R6: wrong value keeps open, right value closes
        io_wr(IDX, 8'h02, "R6"); io_rd(DAT, "R6");
        io_wr(DAT, 8'h03, "R6"); io_rd(IDX, "R6");
        io_wr(DAT, 8'h02, "R6"); io_rd(IDX, "R6");
        check("R6 closed", 32'(m_open), 32'd0);
        // Random mix (R2, R12)
        for (int n = 0; n < 1500; n++) begin
            r = $urandom % 16;
            case (r)
                0:  unlock("R2");
                1:  begin io_wr(IDX, 8'h02, "R6"); io_wr(DAT, 8'h02, "R6"); end
                2, 3: io_wr(IDX, pick_reg($urandom), "R5");
                4, 5, 6, 7, 8: begin
                    d = (m_idx == 8'h07) ? 8'($urandom % 12) : 8'($urandom % 256);
                    if (m_idx == 8'h02 && d == 8'h02) d = 8'h00;
                    io_wr(DAT, d, "R12");
                end
                9, 10, 11, 12: io_rd(DAT, "R12");
                13: io_rd(IDX, "R5");
                14: io_wr(IDX, 8'($urandom % 256), "R3");
                default: io_wr(16'h004E, 8'($urandom % 256), "R13");
            endcase
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule